// File: doc/BRIEF.md
# PHY Link Probe Sequencer

This block brings up the management side of an external Ethernet PHY after reset, with no software involved. A start pulse launches a fixed chain of register reads through a simple request/acknowledge port. The chain first reads the two identifier words and compares the assembled identity with an expected value, ignoring the silicon revision nibble. It then reads the control register to find out whether auto-negotiation is enabled. When it is, the block polls the status register, with a bound on the number of polls, until negotiation completes. Finally it reads the link partner's advertised abilities and turns them into a speed flag and a duplex flag.

The bit-level serial management framing is not part of this block. Each register access is a single request, held with its 5-bit address until the port returns an acknowledge with 16 bits of read data. A management-enable output is high while a probe is in progress, so the surrounding logic can gate its serial engine. The outcome is reported as a one-cycle completion pulse and a sticky error flag.

Top module: `phy_probe_seq`

## Requirements
- R1: The identity is {register 2, register 3 with its low four bits forced to 0}, and it is compared with expected_id with its low four bits forced to 0. On a mismatch the probe ends with error high after exactly two reads, and speed_100 and full_duplex are unchanged.
- R2: After a matching identity, register 0 is read. If its bit 12 is 0, the probe ends without error after three reads in total, with no status read, and speed_100 and full_duplex keep their previous values.
- R3: If register 0 bit 12 is 1, one read of register 1 is issued first and its data is discarded, even when that data has bit 5 set. Polling reads of register 1 follow this discarded read.
- R4: The poll budget is timeout_cnt minus 1 polling reads; values 0 and 1 allow none. Polling ends when a returned status has bit 5 set. If the budget runs out first, the probe ends with error high and speed_100 and full_duplex unchanged.
- R5: After completion, register 5 is read and resolved in this priority order: bit 8 gives speed_100=1 and full_duplex=1; otherwise bit 7 gives 1,0; otherwise bit 6 gives 0,1; otherwise 0,0. The probe ends without error.
- R6: Only one request is outstanding. reg_req stays high with reg_addr unchanged until reg_ack is seen.
- R7: done is high for exactly one cycle at the end of each probe. error is updated only at that point and holds until the next accepted start clears it.
- R8: mgmt_en goes high in the cycle after a start is accepted and is low in the cycle where done is high, on both success and failure.
- R9: A start pulse while a probe is running is ignored. Only one done follows, with the result of the probe already in progress.
- R10: After reset, done, error, mgmt_en, speed_100, full_duplex and reg_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a probe when idle |
| expected_id | input | 32 | Identity to match; low nibble ignored |
| timeout_cnt | input | TMO_W | Poll budget plus one |
| reg_req | output | 1 | Register read request |
| reg_addr | output | 5 | Register address of the request |
| reg_ack | input | 1 | Read completed; reg_rdata valid |
| reg_rdata | input | 16 | Register read data |
| done | output | 1 | One-cycle end-of-probe pulse |
| error | output | 1 | Last probe failed; sticky until next start |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | output | 1 | 1 = full duplex |
| mgmt_en | output | 1 | Management access in progress |

## Verification
The assertions assume that reg_ack is only ever high in a cycle where reg_req is high, and only for one cycle per request. They also assume that expected_id and timeout_cnt are stable when start is pulsed. The bench's register model acknowledges only a pending request, after a chosen latency of zero to three cycles, and always drops the acknowledge in the following cycle. The bench changes the identity, control, status and partner settings only while the block is idle, so the held-request and stable-mode properties are exercised without any input misbehaving.

// File: rtl/phy_probe_pkg.sv
package phy_probe_pkg;

  localparam logic [4:0] ADDR_CTRL    = 5'd0;
  localparam logic [4:0] ADDR_STAT    = 5'd1;
  localparam logic [4:0] ADDR_IDHI    = 5'd2;
  localparam logic [4:0] ADDR_IDLO    = 5'd3;
  localparam logic [4:0] ADDR_PARTNER = 5'd5;

  localparam int BIT_AN_ON   = 12;
  localparam int BIT_AN_DONE = 5;
  localparam int BIT_F100    = 8;
  localparam int BIT_H100    = 7;
  localparam int BIT_F10     = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_IDHI, S_RD_IDLO, S_CHK_ID, S_RD_CTRL,
    S_RD_DUMMY, S_POLL_GATE, S_RD_STAT, S_RD_PARTNER
  } probe_state_t;

  typedef struct packed {
    logic fast;
    logic full;
  } link_mode_t;

  function automatic logic [31:0] form_identity(logic [15:0] hi, logic [15:0] lo);
    return {hi, lo & 16'hFFF0};
  endfunction

  function automatic logic [31:0] strip_revision(logic [31:0] id);
    return id & 32'hFFFF_FFF0;
  endfunction

  // ab[2] = 100 full, ab[1] = 100 half, ab[0] = 10 full
  function automatic link_mode_t pick_mode(logic [2:0] ab);
    link_mode_t m;
    if (ab[2])      m = '{fast: 1'b1, full: 1'b1};
    else if (ab[1]) m = '{fast: 1'b1, full: 1'b0};
    else if (ab[0]) m = '{fast: 1'b0, full: 1'b1};
    else            m = '{fast: 1'b0, full: 1'b0};
    return m;
  endfunction

endpackage

// File: rtl/probe_id_match.sv
module probe_id_match
  import phy_probe_pkg::*;
(
  input  logic [15:0] id_hi,
  input  logic [15:0] id_lo,
  input  logic [31:0] expected_id,
  output logic        id_ok
);
  logic [31:0] seen_id;
  logic [31:0] want_id;

  always_comb begin
    seen_id = form_identity(id_hi, id_lo);
    want_id = strip_revision(expected_id);
    id_ok   = (seen_id == want_id);
  end
endmodule

// File: rtl/probe_ability_resolve.sv
module probe_ability_resolve
  import phy_probe_pkg::*;
(
  input  logic [2:0] abilities,
  output logic       mode_fast,
  output logic       mode_full
);
  link_mode_t m;

  always_comb begin
    m         = pick_mode(abilities);
    mode_fast = m.fast;
    mode_full = m.full;
  end
endmodule

// File: rtl/probe_poll_timer.sv
module probe_poll_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] load_val,
  input  logic             dec,
  output logic             budget_left
);
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (load) count_q <= load_val;
    else if (dec)  count_q <= count_q - ONE;
  end

  assign budget_left = (count_q > ONE);

  // R4: a load captures the requested budget
  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));

  // R4: a decrement removes exactly one poll from the budget
  a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (count_q == $past(count_q) - ONE));
endmodule

// File: rtl/phy_probe_seq.sv
module phy_probe_seq
  import phy_probe_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      expected_id,
  input  logic [TMO_W-1:0] timeout_cnt,
  output logic             reg_req,
  output logic [4:0]       reg_addr,
  input  logic             reg_ack,
  input  logic [15:0]      reg_rdata,
  output logic             done,
  output logic             error,
  output logic             speed_100,
  output logic             full_duplex,
  output logic             mgmt_en
);

  probe_state_t state_q;
  logic [15:0]  id_hi_q, id_lo_q;

  // named internal events
  logic start_accept, ack_fire, id_ok, budget_left, poll_dec;
  logic an_enabled, an_complete, res_fast, res_full;
  logic finish_ok, finish_fail, finish_keep;

  assign start_accept = start && (state_q == S_IDLE);
  assign ack_fire     = reg_req && reg_ack;
  assign an_enabled   = reg_rdata[BIT_AN_ON];
  assign an_complete  = reg_rdata[BIT_AN_DONE];
  assign poll_dec     = (state_q == S_POLL_GATE) && budget_left;

  probe_id_match u_idm (
    .id_hi      (id_hi_q),
    .id_lo      (id_lo_q),
    .expected_id(expected_id),
    .id_ok      (id_ok)
  );

  probe_ability_resolve u_res (
    .abilities({reg_rdata[BIT_F100], reg_rdata[BIT_H100], reg_rdata[BIT_F10]}),
    .mode_fast(res_fast),
    .mode_full(res_full)
  );

  probe_poll_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_accept),
    .load_val   (timeout_cnt),
    .dec        (poll_dec),
    .budget_left(budget_left)
  );

  // request side: one read in flight, address held by state
  always_comb begin
    reg_req  = 1'b1;
    reg_addr = ADDR_CTRL;
    unique case (state_q)
      S_RD_IDHI:    reg_addr = ADDR_IDHI;
      S_RD_IDLO:    reg_addr = ADDR_IDLO;
      S_RD_CTRL:    reg_addr = ADDR_CTRL;
      S_RD_DUMMY,
      S_RD_STAT:    reg_addr = ADDR_STAT;
      S_RD_PARTNER: reg_addr = ADDR_PARTNER;
      default:      reg_req  = 1'b0;
    endcase
  end

  // exit classification
  always_comb begin
    finish_fail = ((state_q == S_CHK_ID) && !id_ok) ||
                  ((state_q == S_POLL_GATE) && !budget_left);
    finish_keep = (state_q == S_RD_CTRL) && ack_fire && !an_enabled;
    finish_ok   = finish_keep || ((state_q == S_RD_PARTNER) && ack_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      id_hi_q     <= '0;
      id_lo_q     <= '0;
      done        <= 1'b0;
      error       <= 1'b0;
      mgmt_en     <= 1'b0;
      speed_100   <= 1'b0;
      full_duplex <= 1'b0;
    end else begin
      done <= 1'b0;
      if (finish_ok || finish_fail) begin
        done    <= 1'b1;
        error   <= finish_fail;
        mgmt_en <= 1'b0;
        state_q <= S_IDLE;
        if (finish_ok && !finish_keep) begin
          speed_100   <= res_fast;
          full_duplex <= res_full;
        end
      end else begin
        unique case (state_q)
          S_IDLE: if (start_accept) begin
            error   <= 1'b0;
            mgmt_en <= 1'b1;
            state_q <= S_RD_IDHI;
          end
          S_RD_IDHI: if (ack_fire) begin
            id_hi_q <= reg_rdata;
            state_q <= S_RD_IDLO;
          end
          S_RD_IDLO: if (ack_fire) begin
            id_lo_q <= reg_rdata;
            state_q <= S_CHK_ID;
          end
          S_CHK_ID:    state_q <= S_RD_CTRL;
          S_RD_CTRL:   if (ack_fire) state_q <= S_RD_DUMMY;
          S_RD_DUMMY:  if (ack_fire) state_q <= S_POLL_GATE;
          S_POLL_GATE: state_q <= S_RD_STAT;
          S_RD_STAT:   if (ack_fire) state_q <= an_complete ? S_RD_PARTNER : S_POLL_GATE;
          default:     state_q <= state_q;
        endcase
      end
    end
  end

  // R6: request held with stable address until acknowledged
  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr)));

  // R7: completion pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: error moves only at completion or after an accepted start
  a_r7_error_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(error) || $past(start_accept)));

  // R8: management released when the probe reports
  a_r8_mgmt_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mgmt_en);

  // R8: no request without management enabled
  a_r8_req_needs_mgmt: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> mgmt_en);

  // R1: an identity mismatch ends the probe with error
  a_r1_mismatch_fails: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_CHK_ID) && !id_ok) |=> (done && error));

  // R4: exhausted budget ends the probe with error
  a_r4_budget_fails: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_POLL_GATE) && !budget_left) |=> (done && error));

  // R2: link mode only changes at completion
  a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(speed_100) && $stable(full_duplex)));

  // R9: a start while busy does not restart the read chain
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q != S_IDLE) && (state_q != S_RD_IDHI)) |=> (state_q != S_RD_IDHI));

endmodule

// File: tb/phy_probe_seq_test.sv
module phy_probe_seq_test;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] expected_id = '0;
  logic [TMO_W-1:0] timeout_cnt = '0;
  logic reg_req;
  logic [4:0] reg_addr;
  logic reg_ack = 1'b0;
  logic [15:0] reg_rdata = '0;
  logic done, error, speed_100, full_duplex, mgmt_en;

  always #5 clk = ~clk;

  phy_probe_seq #(.TMO_W(TMO_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .expected_id(expected_id),
    .timeout_cnt(timeout_cnt), .reg_req(reg_req), .reg_addr(reg_addr),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .done(done), .error(error),
    .speed_100(speed_100), .full_duplex(full_duplex), .mgmt_en(mgmt_en)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // register model
  logic [15:0] m_idhi, m_idlo, m_ctrl, m_lpa;
  int m_ready = 1, m_lat = 0, wait_cnt = 0;
  int stat_rd = 0, tot_rd = 0;

  function automatic logic [15:0] model_read(input logic [4:0] a, input int poll_idx);
    case (a)
      5'd0: return m_ctrl;
      5'd1: return ((m_ready == 0) || (poll_idx >= 1 && poll_idx >= m_ready)) ? 16'h0020 : 16'h0000;
      5'd2: return m_idhi;
      5'd3: return m_idlo;
      5'd5: return m_lpa;
      default: return 16'hDEAD;
    endcase
  endfunction

  always @(negedge clk) begin
    if (reg_ack) begin
      reg_ack = 1'b0;
    end else if (reg_req) begin
      if (wait_cnt >= m_lat) begin
        tot_rd++;
        if (reg_addr == 5'd1) stat_rd++;
        reg_rdata = model_read(reg_addr, stat_rd - 1);
        reg_ack = 1'b1;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  // R6 monitor
  logic p_req = 1'b0, p_ack = 1'b0;
  logic [4:0] p_addr = '0;
  int hold_viol = 0;
  always @(negedge clk) begin
    if (rst_n && p_req && !p_ack && (!reg_req || reg_addr != p_addr)) hold_viol++;
    p_req <= reg_req; p_ack <= reg_ack; p_addr <= reg_addr;
  end

  // scoreboard
  typedef struct {
    bit err; bit spd; bit fd; int stat; int tot; string tag;
  } exp_t;
  exp_t sb[$];
  int completions = 0;
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) chk(0, "R7 done longer than one cycle", 1, 0);
      if (done) begin
        completions++;
        if (sb.size() == 0) begin
          chk(0, "R9 unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(error == e.err, {e.tag, " error"}, int'(error), int'(e.err));
          chk(speed_100 == e.spd, {e.tag, " speed_100"}, int'(speed_100), int'(e.spd));
          chk(full_duplex == e.fd, {e.tag, " full_duplex"}, int'(full_duplex), int'(e.fd));
          chk(stat_rd == e.stat, {e.tag, " status reads"}, stat_rd, e.stat);
          chk(tot_rd == e.tot, {e.tag, " total reads"}, tot_rd, e.tot);
          chk(!mgmt_en, "R8 mgmt_en low at done", int'(mgmt_en), 0);
        end
      end
    end
    prev_done <= done;
  end

  bit exp_spd = 0, exp_fd = 0;
  bit hung = 0;

  task automatic run_case(input string tag, input logic [15:0] idhi, input logic [15:0] idlo,
                          input logic [31:0] want, input logic [15:0] ctrl, input logic [15:0] lpa,
                          input int ready, input int tmo, input int lat, input bit busy_start);
    exp_t e;
    int base, budget, need;
    if (hung) return;
    m_idhi = idhi; m_idlo = idlo; m_ctrl = ctrl; m_lpa = lpa;
    m_ready = ready; m_lat = lat; stat_rd = 0; tot_rd = 0; wait_cnt = 0;
    expected_id = want; timeout_cnt = TMO_W'(tmo);
    e.tag = tag; e.err = 0; e.stat = 0;
    if ({idhi, idlo & 16'hFFF0} != (want & 32'hFFFF_FFF0)) begin
      e.err = 1; e.tot = 2;
    end else if (!ctrl[12]) begin
      e.tot = 3;
    end else begin
      budget = (tmo > 1) ? tmo - 1 : 0;
      need   = (ready == 0) ? 1 : ready;
      if (need <= budget) begin
        e.stat = 1 + need; e.tot = 5 + need;
        if (lpa[8])      begin exp_spd = 1; exp_fd = 1; end
        else if (lpa[7]) begin exp_spd = 1; exp_fd = 0; end
        else if (lpa[6]) begin exp_spd = 0; exp_fd = 1; end
        else             begin exp_spd = 0; exp_fd = 0; end
      end else begin
        e.err = 1; e.stat = 1 + budget; e.tot = 4 + budget;
      end
    end
    e.spd = exp_spd; e.fd = exp_fd;
    sb.push_back(e);
    base = completions;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(mgmt_en == 1'b1, "R8 mgmt_en high after start", int'(mgmt_en), 1);
    chk(error == 1'b0, "R7 error cleared by start", int'(error), 0);
    if (busy_start) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      if (completions != base) break;
    end
    if (completions == base) begin
      chk(0, {tag, " watchdog"}, 0, 1);
      hung = 1;
      return;
    end
    repeat (4) @(negedge clk);
    chk(error == e.err, "R7 error held after done", int'(error), int'(e.err));
    chk(sb.size() == 0, "R9 single completion", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !error && !mgmt_en && !reg_req, "R10 reset controls", int'({done, error, mgmt_en, reg_req}), 0);
    chk(!speed_100 && !full_duplex, "R10 reset mode", int'({speed_100, full_duplex}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case("R1 R2 revision nibble ignored, negotiation off", 16'h0181, 16'hB8A7, 32'h0181_B8AA, 16'h0000, 16'h0000, 1, 5, 0, 0);
    run_case("R1 upper id mismatch",   16'h0022, 16'h1610, 32'h0022_1710, 16'h1000, 16'h0100, 1, 5, 1, 0);
    run_case("R5 100 full priority",   16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h01E1, 3, 10, 0, 0);
    run_case("R5 100 half priority",   16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h00C1, 2, 10, 2, 0);
    run_case("R5 10 full",             16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h0041, 1, 10, 1, 0);
    run_case("R2 negotiation off keeps mode", 16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'hEFFF, 16'h0100, 1, 10, 3, 0);
    run_case("R4 budget exhausted",    16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h0100, 10, 4, 0, 0);
    run_case("R4 budget one",          16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h0100, 0, 1, 1, 0);
    run_case("R4 budget zero",         16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h0100, 0, 0, 0, 0);
    run_case("R4 completes on last poll", 16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h0080, 3, 4, 2, 0);
    run_case("R5 10 half fallback",    16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h001F, 1, 4, 0, 0);
    run_case("R3 dummy status discarded", 16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h0100, 0, 6, 1, 0);
    run_case("R9 start while busy",    16'h0007, 16'hC0F1, 32'h0007_C0F0, 16'h1000, 16'h0040, 2, 8, 3, 1);
    chk(hold_viol == 0, "R6 request held until ack", hold_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule